// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Atomic Bit Set and Clear

This block is a bank of general-purpose pins that software reaches through a small 32-bit register bus. One register holds a per-pin direction mask and another holds the output levels. A third register holds the pin levels, captured through a synchronizer. A configuration register carries an auto-idle flag, and a fixed revision word identifies the bank.

Software can write the output register directly. Two alias addresses also change it: one sets the bits written as 1 and the other clears them. A single pin can therefore be changed without a read-modify-write sequence, and other agents that touch neighbouring pins cannot race with it.

Reads are pipelined and return on a one-cycle valid pulse. Their latency is fixed per register. The auto-idle flag lengthens only reads of the captured pin levels. One read is in flight at a time.

Top module: `pinbank_top`

## Requirements
- R1: After reset the direction mask is all ones, so every pin is an input. The output register and the configuration register are zero, pad_oe_n is all ones and pad_out is zero.
- R2: The direction mask sits at byte offset 0x134 and can be written and read. It is active-low: bit value 0 makes a pin an output and 1 makes it an input. pad_oe_n shows the new mask in the cycle after the write.
- R3: The output register sits at byte offset 0x13C and can be written and read directly. pad_out shows the new value in the cycle after the write.
- R4: A write to byte offset 0x194 sets each output bit whose write-data bit is 1 and leaves every other output bit unchanged.
- R5: A write to byte offset 0x190 clears each output bit whose write-data bit is 1 and leaves every other output bit unchanged. Reads of 0x190 and 0x194 return the output register.
- R6: The pin-level register sits at byte offset 0x138. If pad_in changes in cycle 0, a read issued in cycle 2 sees the new level and a read issued in cycle 1 sees the old one. Writes to 0x138 have no effect.
- R7: The configuration register sits at byte offset 0x010. Bit 0 is the auto-idle flag, and all other bits read as zero.
- R8: If bus_rd is high in cycle 0, bus_rvalid pulses for one cycle in cycle 2. For a read of 0x138 while auto-idle is 1, the pulse comes in cycle 3 instead.
- R9: A bus_rd raised while an earlier read has not yet returned is dropped. It produces no response.
- R10: Byte offset 0x000 returns the fixed REV_ID word and ignores writes. Any other offset, including unaligned ones, reads zero and ignores writes.
- R11: A read and a write to the same register in the same cycle return the value from before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read request strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | One-cycle read-complete pulse |
| pad_in | input | N_PINS | Asynchronous pin levels |
| pad_out | output | N_PINS | Output levels to the pads |
| pad_oe_n | output | N_PINS | Active-low per-pin output enable |

## Verification
The two functions that can share a cycle are a register write and a read request, because both use one address bus. The bench drives bus_wr and bus_rd together at the output-register offset. The returned word must be the value from before the write, and a following read must return the value that was written. A second pairing is tested as well: a read raised while another is still in flight must produce exactly one response pulse, and that pulse must carry the first read's data.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int DW = 32;

    localparam logic [31:0] OFS_REV  = 32'h000;
    localparam logic [31:0] OFS_CFG  = 32'h010;
    localparam logic [31:0] OFS_OE   = 32'h134;
    localparam logic [31:0] OFS_DIN  = 32'h138;
    localparam logic [31:0] OFS_DOUT = 32'h13C;
    localparam logic [31:0] OFS_CLR  = 32'h190;
    localparam logic [31:0] OFS_SET  = 32'h194;

    typedef enum logic [2:0] {
        SEL_REV, SEL_CFG, SEL_OE, SEL_DIN, SEL_DOUT, SEL_CLR, SEL_SET, SEL_NONE
    } regsel_e;

    function automatic regsel_e decode(input logic [31:0] ofs);
        case (ofs)
            OFS_REV:  return SEL_REV;
            OFS_CFG:  return SEL_CFG;
            OFS_OE:   return SEL_OE;
            OFS_DIN:  return SEL_DIN;
            OFS_DOUT: return SEL_DOUT;
            OFS_CLR:  return SEL_CLR;
            OFS_SET:  return SEL_SET;
            default:  return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int N_PINS = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] din
);
    typedef struct packed {
        logic [STAGES-1:0][N_PINS-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = pad_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign din = st_q.chain[STAGES-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int          N_PINS = 32,
    parameter int          ADDR_W = 12,
    parameter logic [31:0] REV_ID = 32'h0051_0C02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [N_PINS-1:0] din,
    output logic [DW-1:0]     rd_word,
    output logic              rd_long,
    output logic [N_PINS-1:0] oe_n,
    output logic [N_PINS-1:0] dout
);
    typedef struct packed {
        logic [N_PINS-1:0] oe_n;
        logic [N_PINS-1:0] dout;
        logic              autoidle;
    } regs_t;

    regs_t   st_d, st_q;
    regsel_e sel;
    logic [N_PINS-1:0] wbits;

    assign sel   = decode(32'(addr));
    assign wbits = wdata[N_PINS-1:0];

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (sel)
                SEL_CFG:  st_d.autoidle = wdata[0];
                SEL_OE:   st_d.oe_n     = wbits;
                SEL_DOUT: st_d.dout     = wbits;
                SEL_SET:  st_d.dout     = st_q.dout | wbits;
                SEL_CLR:  st_d.dout     = st_q.dout & ~wbits;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.oe_n     <= '1;
            st_q.dout     <= '0;
            st_q.autoidle <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_REV:                    rd_word = REV_ID;
            SEL_CFG:                    rd_word[0] = st_q.autoidle;
            SEL_OE:                     rd_word[N_PINS-1:0] = st_q.oe_n;
            SEL_DIN:                    rd_word[N_PINS-1:0] = din;
            SEL_DOUT, SEL_SET, SEL_CLR: rd_word[N_PINS-1:0] = st_q.dout;
            default:                    rd_word = '0;
        endcase
    end

    assign rd_long = (sel == SEL_DIN) && st_q.autoidle;
    assign oe_n    = st_q.oe_n;
    assign dout    = st_q.dout;

    // R4: bits written as 1 become set, all other bits keep their value
    p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_SET) |=>
            (((st_q.dout & $past(wbits)) == $past(wbits)) &&
             ((st_q.dout & ~$past(wbits)) == ($past(st_q.dout) & ~$past(wbits)))));

    // R5: bits written as 1 become clear, all other bits keep their value
    p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_CLR) |=>
            (((st_q.dout & $past(wbits)) == '0) &&
             ((st_q.dout & ~$past(wbits)) == ($past(st_q.dout) & ~$past(wbits)))));

    // R10: writes to revision or unmapped offsets change no state
    p_ignored_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == SEL_NONE || sel == SEL_REV || sel == SEL_DIN)) |=>
            ($stable(st_q.oe_n) && $stable(st_q.dout) && $stable(st_q.autoidle)));
endmodule

// File: rtl/pinbank_rdpath.sv
module pinbank_rdpath
    import pinbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          rd_long,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    typedef struct packed {
        logic          s1_v;
        logic          s1_long;
        logic [DW-1:0] s1_data;
        logic          s2_v;
        logic [DW-1:0] s2_data;
        logic          out_v;
        logic [DW-1:0] out_data;
    } rdp_t;

    rdp_t st_d, st_q;
    logic busy, accept;

    assign busy   = st_q.s1_v || st_q.s2_v;
    assign accept = rd_req && !busy;

    always_comb begin
        st_d         = st_q;
        st_d.s1_v    = accept;
        st_d.s1_long = accept && rd_long;
        st_d.s2_v    = 1'b0;
        st_d.out_v   = 1'b0;
        if (accept) st_d.s1_data = rd_word;
        if (st_q.s1_v && st_q.s1_long) begin
            st_d.s2_v    = 1'b1;
            st_d.s2_data = st_q.s1_data;
        end else if (st_q.s1_v) begin
            st_d.out_v    = 1'b1;
            st_d.out_data = st_q.s1_data;
        end
        if (st_q.s2_v) begin
            st_d.out_v    = 1'b1;
            st_d.out_data = st_q.s2_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.out_data;
    assign rvalid = st_q.out_v;

    // R8: short reads answer two cycles after the request
    p_short_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !rd_long) |-> ##2 rvalid);

    // R8: long reads stay silent for two cycles and answer in the third
    p_long_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rd_long) |-> ##2 (!rvalid) ##1 rvalid);

    // R8: the valid strobe never lasts beyond one cycle
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R9: a request raised while busy starts nothing
    p_drop_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && busy && !st_q.s2_v && !st_q.s1_long) |=> !st_q.s1_v);
endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
    import pinbank_pkg::*;
#(
    parameter int          N_PINS = 32,
    parameter int          ADDR_W = 12,
    parameter int          STAGES = 2,
    parameter logic [31:0] REV_ID = 32'h0051_0C02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe_n
);
    logic [N_PINS-1:0] din;
    logic [DW-1:0]     rd_word;
    logic              rd_long;

    pinbank_sync #(.N_PINS(N_PINS), .STAGES(STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .din(din)
    );

    pinbank_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .REV_ID(REV_ID)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .din(din), .rd_word(rd_word), .rd_long(rd_long),
        .oe_n(pad_oe_n), .dout(pad_out)
    );

    pinbank_rdpath rdpath_i (
        .clk(clk), .rst_n(rst_n), .rd_req(bus_rd), .rd_long(rd_long),
        .rd_word(rd_word), .rdata(bus_rdata), .rvalid(bus_rvalid)
    );
endmodule

// File: tb/pinbank_top_tb_top.sv
module pinbank_top_tb_top;
    localparam logic [31:0] REV = 32'h0051_0C02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pinbank_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe_n(pad_oe_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output int lat);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        lat = 1;
        while (!bus_rvalid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        d = bus_rdata;
    endtask

    task automatic read_check(input string req, input logic [11:0] a,
                              input logic [31:0] exp, input int exp_lat);
        logic [31:0] d;
        int lat;
        bus_read(a, d, lat);
        check(req, d, exp);
        check({req, " latency"}, lat, exp_lat);
    endtask

    task automatic t_reset;
        check("R1 pad_oe_n", pad_oe_n, 32'hFFFF_FFFF);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
        read_check("R1 cfg", 12'h010, 32'h0, 2);
        read_check("R1 oe", 12'h134, 32'hFFFF_FFFF, 2);
    endtask

    task automatic t_oe_dout;
        bus_write(12'h134, 32'h0F0F_00FF);
        check("R2 pad_oe_n", pad_oe_n, 32'h0F0F_00FF);
        read_check("R2 oe read", 12'h134, 32'h0F0F_00FF, 2);
        bus_write(12'h13C, 32'hA5A5_5A5A);
        check("R3 pad_out", pad_out, 32'hA5A5_5A5A);
        read_check("R3 dout read", 12'h13C, 32'hA5A5_5A5A, 2);
    endtask

    task automatic t_set_clr;
        bus_write(12'h13C, 32'h0000_F00F);
        bus_write(12'h194, 32'h8000_0101);
        check("R4 set", pad_out, 32'h8000_F10F);
        bus_write(12'h194, 32'h0);
        check("R4 set zero", pad_out, 32'h8000_F10F);
        bus_write(12'h190, 32'h0000_300E);
        check("R5 clear", pad_out, 32'h8000_C101);
        bus_write(12'h190, 32'h0);
        check("R5 clear zero", pad_out, 32'h8000_C101);
        read_check("R5 read clr alias", 12'h190, 32'h8000_C101, 2);
        read_check("R5 read set alias", 12'h194, 32'h8000_C101, 2);
    endtask

    task automatic t_datain;
        @(negedge clk);
        pad_in = 32'h1234_5678;
        repeat (4) @(negedge clk);
        @(negedge clk);
        pad_in = 32'hCAFE_0001;
        read_check("R6 one cycle old", 12'h138, 32'h1234_5678, 2);
        read_check("R6 settled", 12'h138, 32'hCAFE_0001, 2);
        @(negedge clk);
        pad_in = 32'h0BAD_F00D;
        @(negedge clk);
        read_check("R6 two cycles new", 12'h138, 32'h0BAD_F00D, 2);
        bus_write(12'h138, 32'hFFFF_0000);
        read_check("R6 write ignored", 12'h138, 32'h0BAD_F00D, 2);
    endtask

    task automatic t_cfg_latency;
        bus_write(12'h010, 32'hFFFF_FFFF);
        read_check("R7 cfg bit0 only", 12'h010, 32'h1, 2);
        read_check("R8 datain autoidle", 12'h138, 32'h0BAD_F00D, 3);
        read_check("R8 oe autoidle", 12'h134, 32'h0F0F_00FF, 2);
        bus_write(12'h010, 32'h0);
        read_check("R7 cfg cleared", 12'h010, 32'h0, 2);
        read_check("R8 datain normal", 12'h138, 32'h0BAD_F00D, 2);
    endtask

    task automatic t_overlap;
        int n = 0;
        logic [31:0] got = '0;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 12'h134;
        @(negedge clk);
        if (bus_rvalid) begin n++; got = bus_rdata; end
        bus_addr = 12'h000;
        @(negedge clk);
        if (bus_rvalid) begin n++; got = bus_rdata; end
        bus_rd = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (bus_rvalid) begin n++; got = bus_rdata; end
        end
        check("R9 single response", n, 1);
        check("R9 first read data", got, 32'h0F0F_00FF);
    endtask

    task automatic t_rev_unmapped;
        read_check("R10 revision", 12'h000, REV, 2);
        bus_write(12'h000, 32'h0);
        read_check("R10 revision ro", 12'h000, REV, 2);
        bus_write(12'h200, 32'hFFFF_FFFF);
        bus_write(12'h136, 32'h0);
        bus_write(12'h004, 32'h1);
        read_check("R10 unmapped read", 12'h200, 32'h0, 2);
        read_check("R10 oe intact", 12'h134, 32'h0F0F_00FF, 2);
        read_check("R10 cfg intact", 12'h010, 32'h0, 2);
        check("R10 pad_out intact", pad_out, 32'h8000_C101);
    endtask

    task automatic t_rw_same;
        int n = 0;
        logic [31:0] got = '0;
        bus_write(12'h13C, 32'h1111_2222);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h13C; bus_wdata = 32'h3333_4444;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (bus_rvalid) begin n++; got = bus_rdata; end
            @(negedge clk);
        end
        check("R11 one response", n, 1);
        check("R11 old value", got, 32'h1111_2222);
        check("R11 write landed pad", pad_out, 32'h3333_4444);
        read_check("R11 write landed read", 12'h13C, 32'h3333_4444, 2);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oe_dout();
        t_set_clr();
        t_datain();
        t_cfg_latency();
        t_overlap();
        t_rev_unmapped();
        t_rw_same();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule